// File: doc/BRIEF.md
# Interlaced Field Line Address Generator

This block walks a frame one line at a time and hands out, for every line, the address to fetch the source line from, the address to store the produced line to, and a flag that says whether the store should happen or the line should be thrown away. It turns a progressive frame into interlaced video in one of two ways.

In input interlacing it reads only the even or only the odd source lines, so the produced image is a single field. In output interlacing it reads every source line and sends even lines to one field buffer and odd lines to another, so both fields come out of one pass. A field that is not wanted can be discarded.

A start pulse captures the configuration. The block then offers lines through a valid/ready handshake. It ends each job with a one-cycle done pulse, or with a one-cycle configuration-error pulse if the settings cannot be combined. The controller has four states:

- `S_IDLE`: waits for start. On a start it moves to `S_FAULT` on a bad configuration, to `S_DONE` when there are zero lines, and to `S_LINE` otherwise.
- `S_LINE`: offers one line per handshake. It moves to `S_DONE` when the last line is accepted.
- `S_DONE`: pulses done and then returns to `S_IDLE`.
- `S_FAULT`: pulses the error and then returns to `S_IDLE`.

Top module: `ilace_addr_gen`

## Requirements
- R1: After reset the block is idle, with `ln_valid`, `done`, `cfg_err` and `busy` all low.
- R2: With `in_sel`=00 and `out_sel`=00 (progressive), the block produces `frame_lines` lines. Line n has source `src_base + n*src_stride`, destination `buf0_base + n*dst_stride`, and `ln_write`=1.
- R3: With `in_sel`=01 (field 0) or 10 (field 1) and `out_sel`=00, the block produces floor(`frame_lines`/2) lines. Line k has source `src_base + (2k+f)*src_stride`, where f is 0 for 01 and 1 for 10, destination `buf0_base + k*dst_stride`, and `ln_write`=1.
- R4: With `out_sel` non-zero and `in_sel`=00, the block produces `frame_lines` lines. Line n has source `src_base + n*src_stride`. An even n has destination `buf0_base + (n/2)*dst_stride`, and an odd n has destination `buf1_base + (n/2)*dst_stride`.
- R5: In output interlacing, `out_sel` bit 0 enables field 0 (even lines) and bit 1 enables field 1 (odd lines). Lines of a disabled field are still offered, with `ln_write`=0. `ln_write`=0 never occurs in the other modes.
- R6: While `ln_valid` is high and `ln_ready` is low, `ln_valid`, both addresses and `ln_write` hold their values.
- R7: A job with zero lines (`frame_lines`=0, or input interlacing with `frame_lines`=1) offers no line and pulses `done` in the cycle after start.
- R8: `done` rises in the cycle after the last line is accepted. It lasts one cycle, and the block is then idle.
- R9: A start with `in_sel`=11, with both `in_sel` and `out_sel` non-zero, or with `out_sel` non-zero while `two_plane`=1, pulses `cfg_err` for one cycle in the cycle after start. It offers no line and gives no `done`.
- R10: A start while busy is ignored. Configuration changes after the start cycle do not affect the running job.
- R11: `two_plane`=1 is accepted in progressive and input-interlacing modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job start pulse, sampled in idle |
| in_sel | input | 2 | Input field select (00 off, 01 field 0, 10 field 1) |
| out_sel | input | 2 | Output mode (00 progressive, 01 field 0, 10 field 1, 11 both) |
| two_plane | input | 1 | Two-plane output format selected |
| src_base | input | AW | Source frame base address |
| buf0_base | input | AW | Field 0 / progressive output base |
| buf1_base | input | AW | Field 1 output base |
| src_stride | input | AW | Source line stride |
| dst_stride | input | AW | Output line stride |
| frame_lines | input | LW | Source frame height in lines |
| ln_valid | output | 1 | A line address is offered |
| ln_ready | input | 1 | Consumer accepts the offered line |
| ln_src_addr | output | AW | Source line address |
| ln_dst_addr | output | AW | Destination line address |
| ln_write | output | 1 | 1 = store the line, 0 = discard it |
| done | output | 1 | One-cycle end-of-job pulse |
| cfg_err | output | 1 | One-cycle configuration-error pulse |
| busy | output | 1 | A job is in progress |

## Verification
The bench builds the block with AW=24 and LW=6. The narrow line count brings the largest frame, 63 lines, within a short run. That frame is odd in height, so the round-down of the field count is exercised, and both field pointers step through many strides. A 24-bit address also keeps the expected-address arithmetic in the bench cheap, while leaving the bases far enough apart that any mix-up between the two buffers shows in the compared values.

// File: rtl/ilace_pkg.sv
package ilace_pkg;

    typedef enum logic [1:0] {
        WALK_PROG = 2'd0,
        WALK_IN   = 2'd1,
        WALK_OUT  = 2'd2
    } walk_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LINE  = 2'd1,
        S_DONE  = 2'd2,
        S_FAULT = 2'd3
    } state_e;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_F0   = 2'b01;
    localparam logic [1:0] SEL_F1   = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

    localparam int NUM_FIELDS = 2;

endpackage

// File: rtl/ilace_cfg_check.sv
module ilace_cfg_check
    import ilace_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic [1:0]    in_sel,
    input  logic [1:0]    out_sel,
    input  logic          two_plane,
    input  logic [LW-1:0] frame_lines,
    output logic          bad,
    output walk_e         walk,
    output logic [LW-1:0] lines,
    output logic          in_odd,
    output logic          keep_even,
    output logic          keep_odd
);

    logic in_on;
    logic out_on;

    assign in_on  = (in_sel != SEL_OFF);
    assign out_on = (out_sel != SEL_OFF);

    always_comb begin
        bad = 1'b0;
        if (in_sel == SEL_BOTH) bad = 1'b1;
        if (in_on && out_on)    bad = 1'b1;
        if (out_on && two_plane) bad = 1'b1;
    end

    always_comb begin
        if (in_on)       walk = WALK_IN;
        else if (out_on) walk = WALK_OUT;
        else             walk = WALK_PROG;
    end

    assign lines     = (walk == WALK_IN) ? (frame_lines >> 1) : frame_lines;
    assign in_odd    = (in_sel == SEL_F1);
    assign keep_even = (walk != WALK_OUT) || out_sel[0];
    assign keep_odd  = (walk != WALK_OUT) || out_sel[1];

endmodule

// File: rtl/ilace_line_fsm.sv
module ilace_line_fsm
    import ilace_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bad,
    input  logic [LW-1:0] lines,
    input  logic          ln_ready,
    output logic          load,
    output logic          step,
    output logic          ln_valid,
    output logic          done,
    output logic          cfg_err,
    output logic          busy
);

    state_e        st_q;
    state_e        st_d;
    logic [LW-1:0] remain_q;
    logic          last_line;

    assign last_line = (remain_q == LW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    if (bad)                 st_d = S_FAULT;
                    else if (lines == '0)    st_d = S_DONE;
                    else                     st_d = S_LINE;
                end
            end
            S_LINE: begin
                if (ln_ready && last_line) st_d = S_DONE;
            end
            S_DONE:  st_d = S_IDLE;
            S_FAULT: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        ln_valid = 1'b0;
        done     = 1'b0;
        cfg_err  = 1'b0;
        busy     = 1'b1;
        unique case (st_q)
            S_IDLE: begin
                busy = 1'b0;
                load = start && !bad;
            end
            S_LINE: begin
                ln_valid = 1'b1;
                step     = ln_ready;
            end
            S_DONE:  done    = 1'b1;
            S_FAULT: cfg_err = 1'b1;
            default: busy    = 1'b0;
        endcase
    end

    // remaining-line counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    remain_q <= '0;
        else if (load) remain_q <= lines;
        else if (step) remain_q <= remain_q - LW'(1);
    end

endmodule

// File: rtl/ilace_ptr_bank.sv
module ilace_ptr_bank
    import ilace_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  walk_e         walk,
    input  logic          in_odd,
    input  logic          keep_even,
    input  logic          keep_odd,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] buf0_base,
    input  logic [AW-1:0] buf1_base,
    input  logic [AW-1:0] src_stride,
    input  logic [AW-1:0] dst_stride,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          wr,
    output walk_e         walk_q
);

    logic [AW-1:0] src_q;
    logic [AW-1:0] ss_q;
    logic [AW-1:0] ds_q;
    logic          par_q;
    logic          ke_q;
    logic          ko_q;
    logic [AW-1:0] src_inc;
    logic [AW-1:0] fld_base [NUM_FIELDS];
    logic [AW-1:0] fld_q    [NUM_FIELDS];
    logic          fld_adv  [NUM_FIELDS];

    assign fld_base[0] = buf0_base;
    assign fld_base[1] = buf1_base;

    // a field pointer advances only on lines that belong to it
    assign fld_adv[0] = (walk_q != WALK_OUT) || !par_q;
    assign fld_adv[1] = (walk_q == WALK_OUT) && par_q;

    assign src_inc = (walk_q == WALK_IN) ? (ss_q << 1) : ss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            ss_q   <= '0;
            ds_q   <= '0;
            par_q  <= 1'b0;
            ke_q   <= 1'b0;
            ko_q   <= 1'b0;
            walk_q <= WALK_PROG;
        end else if (load) begin
            src_q  <= in_odd ? (src_base + src_stride) : src_base;
            ss_q   <= src_stride;
            ds_q   <= dst_stride;
            par_q  <= 1'b0;
            ke_q   <= keep_even;
            ko_q   <= keep_odd;
            walk_q <= walk;
        end else if (step) begin
            src_q <= src_q + src_inc;
            par_q <= (walk_q == WALK_OUT) ? !par_q : 1'b0;
        end
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  fld_q[f] <= '0;
            else if (load)               fld_q[f] <= fld_base[f];
            else if (step && fld_adv[f]) fld_q[f] <= fld_q[f] + ds_q;
        end
    end

    assign src_addr = src_q;
    assign dst_addr = ((walk_q == WALK_OUT) && par_q) ? fld_q[1] : fld_q[0];
    assign wr       = par_q ? ko_q : ke_q;

endmodule

// File: rtl/ilace_addr_gen.sv
module ilace_addr_gen
    import ilace_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    in_sel,
    input  logic [1:0]    out_sel,
    input  logic          two_plane,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] buf0_base,
    input  logic [AW-1:0] buf1_base,
    input  logic [AW-1:0] src_stride,
    input  logic [AW-1:0] dst_stride,
    input  logic [LW-1:0] frame_lines,
    output logic          ln_valid,
    input  logic          ln_ready,
    output logic [AW-1:0] ln_src_addr,
    output logic [AW-1:0] ln_dst_addr,
    output logic          ln_write,
    output logic          done,
    output logic          cfg_err,
    output logic          busy
);

    logic          bad;
    walk_e         walk;
    walk_e         walk_q;
    logic [LW-1:0] lines;
    logic          in_odd;
    logic          keep_even;
    logic          keep_odd;
    logic          load;
    logic          step;

    ilace_cfg_check #(.LW(LW)) u_cfg (
        .in_sel      (in_sel),
        .out_sel     (out_sel),
        .two_plane   (two_plane),
        .frame_lines (frame_lines),
        .bad         (bad),
        .walk        (walk),
        .lines       (lines),
        .in_odd      (in_odd),
        .keep_even   (keep_even),
        .keep_odd    (keep_odd)
    );

    ilace_line_fsm #(.LW(LW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bad      (bad),
        .lines    (lines),
        .ln_ready (ln_ready),
        .load     (load),
        .step     (step),
        .ln_valid (ln_valid),
        .done     (done),
        .cfg_err  (cfg_err),
        .busy     (busy)
    );

    ilace_ptr_bank #(.AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .walk       (walk),
        .in_odd     (in_odd),
        .keep_even  (keep_even),
        .keep_odd   (keep_odd),
        .src_base   (src_base),
        .buf0_base  (buf0_base),
        .buf1_base  (buf1_base),
        .src_stride (src_stride),
        .dst_stride (dst_stride),
        .src_addr   (ln_src_addr),
        .dst_addr   (ln_dst_addr),
        .wr         (ln_write),
        .walk_q     (walk_q)
    );

endmodule

// File: rtl/ilace_addr_gen_chk.sv
module ilace_addr_gen_chk
    import ilace_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ln_valid,
    input logic          ln_ready,
    input logic [AW-1:0] ln_src_addr,
    input logic [AW-1:0] ln_dst_addr,
    input logic          ln_write,
    input logic          done,
    input logic          cfg_err,
    input logic          busy,
    input walk_e         walk_q
);

    a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && !ln_ready) |=> (ln_valid && $stable(ln_src_addr)
                                     && $stable(ln_dst_addr) && $stable(ln_write)));

    a_r8_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!ln_valid && !done));

    a_r9_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !busy);

    a_r10_launch_by_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r5_skip_only_out: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && !ln_write) |-> (walk_q == WALK_OUT));

endmodule

bind ilace_addr_gen ilace_addr_gen_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ln_valid    (ln_valid),
    .ln_ready    (ln_ready),
    .ln_src_addr (ln_src_addr),
    .ln_dst_addr (ln_dst_addr),
    .ln_write    (ln_write),
    .done        (done),
    .cfg_err     (cfg_err),
    .busy        (busy),
    .walk_q      (walk_q)
);

// File: tb/ilace_addr_gen_bench.sv
module ilace_addr_gen_bench;

    localparam int AW = 24;
    localparam int LW = 6;

    typedef struct {
        logic [AW-1:0] s;
        logic [AW-1:0] d;
        logic          w;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    in_sel = 2'b00;
    logic [1:0]    out_sel = 2'b00;
    logic          two_plane = 1'b0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] buf0_base = '0;
    logic [AW-1:0] buf1_base = '0;
    logic [AW-1:0] src_stride = '0;
    logic [AW-1:0] dst_stride = '0;
    logic [LW-1:0] frame_lines = '0;
    logic          ln_valid;
    logic          ln_ready = 1'b1;
    logic [AW-1:0] ln_src_addr;
    logic [AW-1:0] ln_dst_addr;
    logic          ln_write;
    logic          done;
    logic          cfg_err;
    logic          busy;

    ilace_addr_gen #(.AW(AW), .LW(LW)) u_ilace_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .in_sel(in_sel), .out_sel(out_sel),
        .two_plane(two_plane), .src_base(src_base), .buf0_base(buf0_base),
        .buf1_base(buf1_base), .src_stride(src_stride), .dst_stride(dst_stride),
        .frame_lines(frame_lines), .ln_valid(ln_valid), .ln_ready(ln_ready),
        .ln_src_addr(ln_src_addr), .ln_dst_addr(ln_dst_addr), .ln_write(ln_write),
        .done(done), .cfg_err(cfg_err), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    int    ref_cyc = 0;
    bit    job_err = 0;
    bit    job_end = 1;
    bit    stall = 0;
    bit    finished = 0;
    string job_tag = "R1";
    item_t expq[$];

    logic [AW-1:0] sb = 24'h100000;
    logic [AW-1:0] b0 = 24'h200000;
    logic [AW-1:0] b1 = 24'h300000;
    logic [AW-1:0] ss = 24'h000140;
    logic [AW-1:0] ds = 24'h0000A0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // consumer ready pattern, changed away from the sampling edge
    initial forever begin
        @(posedge clk);
        #1 ln_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end

    // monitor / scoreboard
    initial begin
        logic          held = 0;
        logic [AW-1:0] hs = '0;
        logic [AW-1:0] hd = '0;
        logic          hw = 0;
        forever begin
            @(negedge clk);
            if (held) begin
                check(ln_valid && ln_src_addr == hs && ln_dst_addr == hd && ln_write == hw,
                      "R6", "held offer", {ln_src_addr, ln_dst_addr}, {hs, hd});
            end
            held = ln_valid && !ln_ready;
            hs = ln_src_addr; hd = ln_dst_addr; hw = ln_write;
            if (ln_valid && ln_ready) begin
                if (expq.size() == 0) begin
                    check(0, job_tag, "unexpected line", ln_src_addr, 0);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    check(ln_src_addr == e.s, e.tag, "src addr", ln_src_addr, e.s);
                    check(ln_dst_addr == e.d, e.tag, "dst addr", ln_dst_addr, e.d);
                    check(ln_write == e.w, e.tag, "write flag", ln_write, e.w);
                end
                ref_cyc = cyc;
            end
            if (done) begin
                check(!job_err, "R9", "done on bad config", 1, 0);
                check(expq.size() == 0, "R8", "lines left at done", expq.size(), 0);
                check(cyc == ref_cyc + 1, (expq.size() == 0 && ref_cyc >= 0) ? job_tag : "R8",
                      "done cycle", cyc, ref_cyc + 1);
                job_end = 1;
            end
            if (cfg_err) begin
                check(job_err, job_tag, "unexpected cfg_err", 1, 0);
                check(cyc == ref_cyc + 1, "R9", "cfg_err cycle", cyc, ref_cyc + 1);
                job_end = 1;
            end
        end
    end

    task automatic run_job(input logic [1:0] is, input logic [1:0] os, input logic tp,
                           input int h, input bit exp_err, input bit mid_start,
                           input string tag);
        if (!exp_err) begin
            if (is != 2'b00) begin
                int f = (is == 2'b10) ? 1 : 0;
                for (int k = 0; k < h / 2; k++) begin
                    item_t e;
                    e.s = sb + AW'(2 * k + f) * ss;
                    e.d = b0 + AW'(k) * ds;
                    e.w = 1'b1;
                    e.tag = tag;
                    expq.push_back(e);
                end
            end else begin
                for (int n = 0; n < h; n++) begin
                    item_t e;
                    e.s = sb + AW'(n) * ss;
                    if (os == 2'b00) begin
                        e.d = b0 + AW'(n) * ds;
                        e.w = 1'b1;
                    end else begin
                        e.d = ((n % 2) == 1 ? b1 : b0) + AW'(n / 2) * ds;
                        e.w = ((n % 2) == 1) ? os[1] : os[0];
                    end
                    e.tag = tag;
                    expq.push_back(e);
                end
            end
        end
        @(posedge clk);
        #1;
        in_sel = is; out_sel = os; two_plane = tp; frame_lines = LW'(h);
        src_base = sb; buf0_base = b0; buf1_base = b1;
        src_stride = ss; dst_stride = ds;
        job_err = exp_err; job_tag = tag; job_end = 0; ref_cyc = cyc;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        // R10: alter every setting once the job has started
        in_sel = 2'b00; out_sel = 2'b00; two_plane = 1'b0; frame_lines = LW'(3);
        src_base = 24'h0AAAAA; buf0_base = 24'h0BBBBB; buf1_base = 24'h0CCCCC;
        src_stride = 24'h000777; dst_stride = 24'h000555;
        if (mid_start) begin
            @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
        end
        while (!job_end) @(negedge clk);
        @(negedge clk);
        check(!busy && !ln_valid && !done && !cfg_err, "R8", "idle after job",
              {busy, ln_valid, done, cfg_err}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!ln_valid && !done && !cfg_err && !busy, "R1", "reset outputs",
              {ln_valid, done, cfg_err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1", "idle after reset", busy, 0);

        run_job(2'b00, 2'b00, 1'b1, 5, 0, 0, "R2");
        run_job(2'b01, 2'b00, 1'b1, 7, 0, 0, "R3");
        run_job(2'b00, 2'b00, 1'b0, 0, 0, 0, "R7");
        stall = 1;
        run_job(2'b10, 2'b00, 1'b0, 8, 0, 0, "R3");
        run_job(2'b00, 2'b11, 1'b0, 6, 0, 0, "R4");
        run_job(2'b00, 2'b01, 1'b0, 5, 0, 0, "R5");
        run_job(2'b00, 2'b10, 1'b0, 4, 0, 0, "R5");
        run_job(2'b01, 2'b00, 1'b1, 1, 0, 0, "R7");
        run_job(2'b11, 2'b00, 1'b0, 6, 1, 0, "R9");
        run_job(2'b01, 2'b11, 1'b0, 6, 1, 0, "R9");
        run_job(2'b00, 2'b01, 1'b1, 6, 1, 0, "R9");
        run_job(2'b00, 2'b00, 1'b0, 6, 0, 1, "R10");
        run_job(2'b10, 2'b00, 1'b1, 9, 0, 1, "R11");
        ss = 24'h000F00; ds = 24'h000780;
        run_job(2'b00, 2'b11, 1'b0, 63, 0, 0, "R4");
        stall = 0;
        run_job(2'b01, 2'b00, 1'b0, 63, 0, 0, "R3");
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", cyc, 0);
        summary();
    end

endmodule